// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block is the memory-side write path of a single-data-rate SDRAM model. It takes ACTIVATE, PRECHARGE and WRITE commands from a controller. It tracks one open-row flag per bank. It stores the incoming data words into a small internal array that is indexed by bank and column. A WRITE names a bank, a starting column, a burst length and an auto-precharge request. The block captures the word that arrives with the command, then produces the remaining column addresses itself and captures one further word on every rising edge until the burst ends.

A fixed burst runs through its naturally aligned block of columns and wraps inside that block. A full-page burst steps through every column of the page and goes back to column 0, with no limit on length. Any later command cuts a burst short. A new WRITE does so on any cycle, and the word that comes with it belongs to the new burst. Each byte lane has a mask bit that guards it. A read port gives the stored contents to the rest of the model.

Top module: `sdw_write_seq`

## Requirements
- R1: On the rising edge that registers an accepted WRITE (cmd_i = 2), data_i is stored at (bank_i, col_i), subject to mask_i.
- R2: After that edge, one word is stored per edge with no gaps. Burst length comes from blen_i sampled with the WRITE: 0, 1, 2 and 3 select 1, 2, 4 and 8 words, and any value with bit 2 set selects full page. For fixed lengths the column is (start + n) taken modulo the length, kept inside the block aligned to the length.
- R3: Once a fixed burst has stored its last word, data presented with NOP (cmd_i = 0) is not stored, and burst_o is low.
- R4: In full-page mode the column counts up modulo COLS. It wraps from COLS-1 to 0 and continues until some other command arrives.
- R5: A WRITE accepted while a burst is running ends that burst at once. The data on that edge goes to the new command's bank and column.
- R6: A WRITE may follow the last word of a fixed burst on the very next edge, with no idle cycle. This holds for the same bank or a different one.
- R7: With ap_i high, the bank closes on the edge that stores the burst's last word, so bank_open_o for that bank is low in the following cycle. With ap_i low the bank stays open. A burst cut short by a later WRITE does not close its bank.
- R8: mask_i bit i high leaves byte i (data bits 8i+7..8i) of the stored word unchanged. A masked word still uses up its slot in the burst.
- R9: A WRITE to a bank whose flag is clear raises err_o for exactly the next cycle and writes nothing. A burst that is already running carries on as if the cycle were a NOP.
- R10: ACTIVATE (cmd_i = 1) sets the flag of bank_i and PRECHARGE (cmd_i = 3) clears it. Either one ends a running burst without storing data.
- R11: After reset all bank flags are clear, burst_o and err_o are low, and every stored word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command: 0 NOP, 1 ACTIVATE, 2 WRITE, 3 PRECHARGE |
| bank_i | input | BANK_W | Bank for the command |
| col_i | input | COL_W | Starting column of a WRITE |
| ap_i | input | 1 | Auto-precharge request of a WRITE |
| blen_i | input | 3 | Burst length code of a WRITE |
| data_i | input | DATA_W | Write data word |
| mask_i | input | DATA_W/8 | Per-byte write mask, high keeps the old byte |
| rd_bank_i | input | BANK_W | Bank of the read port |
| rd_col_i | input | COL_W | Column of the read port |
| rd_data_o | output | DATA_W | Stored word at the read address |
| bank_open_o | output | BANKS | Open-row flag per bank |
| burst_o | output | 1 | High while more burst words are expected |
| err_o | output | 1 | Pulse after a WRITE to a closed bank |

## Verification
The checker looks at the command-level rules on every cycle. It checks that ACTIVATE and PRECHARGE set and clear the addressed flag and stop any burst. It checks that a multi-word WRITE to an open bank leaves a burst running. It checks that err_o follows only a WRITE to a closed bank. It checks that idle cycles outside a burst leave the read data untouched. Other behaviours can only be shown by the bench's scenarios against its reference array: where each burst word lands, wrap inside aligned blocks and across a full page, truncation, byte masking, and whether auto-precharge fires or is dropped.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } sdw_cmd_e;

    localparam int BLEN_W = 3;

endpackage

// File: rtl/sdw_burst_ctrl.sv
module sdw_burst_ctrl #(
    parameter int BANKS = 4,
    parameter int COLS  = 16,
    localparam int BANK_W = $clog2(BANKS),
    localparam int COL_W  = $clog2(COLS)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      start_i,
    input  logic                      stop_i,
    input  logic [BANK_W-1:0]         bank_i,
    input  logic [COL_W-1:0]          col_i,
    input  logic                      ap_i,
    input  logic [sdw_pkg::BLEN_W-1:0] blen_i,
    output logic                      wr_en_o,
    output logic [BANK_W-1:0]         wr_bank_o,
    output logic [COL_W-1:0]          wr_col_o,
    output logic                      close_o,
    output logic [BANK_W-1:0]         close_bank_o,
    output logic                      active_o
);

    typedef struct packed {
        logic              act;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  base;
        logic [COL_W-1:0]  idx;
        logic [1:0]        lg;
        logic              full;
        logic              ap;
    } burst_st_t;

    burst_st_t st_d, st_q;

    logic [COL_W-1:0] span_mask;
    logic [COL_W-1:0] sum_col;
    logic [COL_W-1:0] step_col;

    always_comb begin
        span_mask = (COL_W'(1) << st_q.lg) - COL_W'(1);
        sum_col   = st_q.base + st_q.idx;
        if (st_q.full) begin
            step_col = sum_col;
        end else begin
            step_col = (st_q.base & ~span_mask) | (sum_col & span_mask);
        end
    end

    always_comb begin
        st_d         = st_q;
        wr_en_o      = 1'b0;
        wr_bank_o    = st_q.bank;
        wr_col_o     = step_col;
        close_o      = 1'b0;
        close_bank_o = st_q.bank;
        if (start_i) begin
            wr_en_o    = 1'b1;
            wr_bank_o  = bank_i;
            wr_col_o   = col_i;
            st_d.bank  = bank_i;
            st_d.base  = col_i;
            st_d.idx   = COL_W'(1);
            st_d.lg    = blen_i[1:0];
            st_d.full  = blen_i[2];
            st_d.ap    = ap_i;
            if (!blen_i[2] && blen_i[1:0] == 2'd0) begin
                st_d.act     = 1'b0;
                close_o      = ap_i;
                close_bank_o = bank_i;
            end else begin
                st_d.act = 1'b1;
            end
        end else if (stop_i) begin
            st_d.act = 1'b0;
        end else if (st_q.act) begin
            wr_en_o  = 1'b1;
            st_d.idx = st_q.idx + COL_W'(1);
            if (!st_q.full && st_q.idx == span_mask) begin
                st_d.act = 1'b0;
                close_o  = st_q.ap;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.act;

endmodule

// File: rtl/sdw_row_tracker.sv
module sdw_row_tracker #(
    parameter int BANKS = 4,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              act_i,
    input  logic              pre_i,
    input  logic [BANK_W-1:0] cmd_bank_i,
    input  logic              close_i,
    input  logic [BANK_W-1:0] close_bank_i,
    output logic [BANKS-1:0]  open_o
);

    typedef struct packed {
        logic [BANKS-1:0] open;
    } row_st_t;

    row_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < BANKS; b++) begin
            if (act_i && cmd_bank_i == BANK_W'(b)) begin
                st_d.open[b] = 1'b1;
            end
            if (pre_i && cmd_bank_i == BANK_W'(b)) begin
                st_d.open[b] = 1'b0;
            end
            if (close_i && close_bank_i == BANK_W'(b)) begin
                st_d.open[b] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = st_q.open;

endmodule

// File: rtl/sdw_word_array.sv
module sdw_word_array #(
    parameter int BANKS  = 4,
    parameter int COLS   = 16,
    parameter int DATA_W = 32,
    localparam int BANK_W = $clog2(BANKS),
    localparam int COL_W  = $clog2(COLS),
    localparam int LANES  = DATA_W / 8,
    localparam int DEPTH  = BANKS * COLS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [BANK_W-1:0] wr_bank_i,
    input  logic [COL_W-1:0]  wr_col_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [LANES-1:0]  wr_mask_i,
    input  logic [BANK_W-1:0] rd_bank_i,
    input  logic [COL_W-1:0]  rd_col_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    logic [BANK_W+COL_W-1:0] wr_addr;
    logic [BANK_W+COL_W-1:0] rd_addr;

    assign wr_addr = {wr_bank_i, wr_col_i};
    assign rd_addr = {rd_bank_i, rd_col_i};

    always_comb begin
        for (int w = 0; w < DEPTH; w++) begin
            mem_d[w] = mem_q[w];
        end
        if (wr_en_i) begin
            for (int l = 0; l < LANES; l++) begin
                if (!wr_mask_i[l]) begin
                    mem_d[wr_addr][l*8 +: 8] = wr_data_i[l*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int w = 0; w < DEPTH; w++) begin
                mem_q[w] <= '0;
            end
        end else begin
            for (int w = 0; w < DEPTH; w++) begin
                mem_q[w] <= mem_d[w];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr];

endmodule

// File: rtl/sdw_write_seq.sv
module sdw_write_seq #(
    parameter int BANKS  = 4,
    parameter int COLS   = 16,
    parameter int DATA_W = 32,
    localparam int BANK_W = $clog2(BANKS),
    localparam int COL_W  = $clog2(COLS),
    localparam int LANES  = DATA_W / 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [1:0]                 cmd_i,
    input  logic [BANK_W-1:0]          bank_i,
    input  logic [COL_W-1:0]           col_i,
    input  logic                       ap_i,
    input  logic [sdw_pkg::BLEN_W-1:0] blen_i,
    input  logic [DATA_W-1:0]          data_i,
    input  logic [LANES-1:0]           mask_i,
    input  logic [BANK_W-1:0]          rd_bank_i,
    input  logic [COL_W-1:0]           rd_col_i,
    output logic [DATA_W-1:0]          rd_data_o,
    output logic [BANKS-1:0]           bank_open_o,
    output logic                       burst_o,
    output logic                       err_o
);

    import sdw_pkg::*;

    typedef struct packed {
        logic err;
    } top_st_t;

    top_st_t st_d, st_q;

    sdw_cmd_e          cmd;
    logic              is_wr;
    logic              is_act;
    logic              is_pre;
    logic              bank_hit;
    logic              wr_start;
    logic              wr_en;
    logic [BANK_W-1:0] wr_bank;
    logic [COL_W-1:0]  wr_col;
    logic              close;
    logic [BANK_W-1:0] close_bank;

    always_comb begin
        cmd      = sdw_cmd_e'(cmd_i);
        is_wr    = (cmd == CMD_WR);
        is_act   = (cmd == CMD_ACT);
        is_pre   = (cmd == CMD_PRE);
        bank_hit = bank_open_o[bank_i];
        wr_start = is_wr && bank_hit;
        st_d     = st_q;
        st_d.err = is_wr && !bank_hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;

    sdw_burst_ctrl #(
        .BANKS (BANKS),
        .COLS  (COLS)
    ) burst_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (wr_start),
        .stop_i       (is_act || is_pre),
        .bank_i       (bank_i),
        .col_i        (col_i),
        .ap_i         (ap_i),
        .blen_i       (blen_i),
        .wr_en_o      (wr_en),
        .wr_bank_o    (wr_bank),
        .wr_col_o     (wr_col),
        .close_o      (close),
        .close_bank_o (close_bank),
        .active_o     (burst_o)
    );

    sdw_row_tracker #(
        .BANKS (BANKS)
    ) rows_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .act_i        (is_act),
        .pre_i        (is_pre),
        .cmd_bank_i   (bank_i),
        .close_i      (close),
        .close_bank_i (close_bank),
        .open_o       (bank_open_o)
    );

    sdw_word_array #(
        .BANKS  (BANKS),
        .COLS   (COLS),
        .DATA_W (DATA_W)
    ) array_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en),
        .wr_bank_i (wr_bank),
        .wr_col_i  (wr_col),
        .wr_data_i (data_i),
        .wr_mask_i (mask_i),
        .rd_bank_i (rd_bank_i),
        .rd_col_i  (rd_col_i),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/sdw_write_seq_chk.sv
module sdw_write_seq_chk #(
    parameter int BANKS  = 4,
    parameter int COLS   = 16,
    parameter int DATA_W = 32,
    localparam int BANK_W = $clog2(BANKS),
    localparam int COL_W  = $clog2(COLS)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [1:0]        cmd_i,
    input logic [BANK_W-1:0] bank_i,
    input logic [2:0]        blen_i,
    input logic [BANK_W-1:0] rd_bank_i,
    input logic [COL_W-1:0]  rd_col_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [BANKS-1:0]  bank_open_o,
    input logic              burst_o,
    input logic              err_o
);

    // R9: a WRITE to a closed bank is flagged on the next cycle
    a_r9_err_on_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == 2'd2 && !bank_open_o[bank_i]) |=> err_o);

    // R9: the flag never follows anything but a WRITE
    a_r9_err_only_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i != 2'd2) |=> !err_o);

    // R10: ACTIVATE opens the addressed bank
    a_r10_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == 2'd1) |=> bank_open_o[$past(bank_i)]);

    // R10: PRECHARGE closes the addressed bank
    a_r10_pre_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == 2'd3) |=> !bank_open_o[$past(bank_i)]);

    // R10: ACTIVATE or PRECHARGE ends a running burst
    a_r10_cmd_ends_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == 2'd1 || cmd_i == 2'd3) |=> !burst_o);

    // R5: an accepted multi-word WRITE leaves a burst running
    a_r5_wr_starts_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == 2'd2 && bank_open_o[bank_i] && blen_i != 3'd0) |=> burst_o);

    // R3: idle cycles outside a burst store nothing
    a_r3_idle_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!burst_o && cmd_i == 2'd0) |=>
        (!($stable(rd_bank_i) && $stable(rd_col_i)) || $stable(rd_data_o)));

endmodule

bind sdw_write_seq sdw_write_seq_chk #(
    .BANKS  (BANKS),
    .COLS   (COLS),
    .DATA_W (DATA_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd_i),
    .bank_i      (bank_i),
    .blen_i      (blen_i),
    .rd_bank_i   (rd_bank_i),
    .rd_col_i    (rd_col_i),
    .rd_data_o   (rd_data_o),
    .bank_open_o (bank_open_o),
    .burst_o     (burst_o),
    .err_o       (err_o)
);

// File: tb/sdw_write_seq_tb.sv
module sdw_write_seq_tb_top;

    localparam int BANKS  = 4;
    localparam int COLS   = 16;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int NVEC   = 34;

    // {cmd[1:0], bank[1:0], col[3:0], ap, blen[2:0], mask[3:0], data[31:0]}
    localparam logic [47:0] VEC [NVEC] = '{
        {2'd2, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hEEEE_0000}, // R9 write to closed bank
        {2'd1, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'h0000_0000}, // R10 open bank 0
        {2'd1, 2'd1, 4'd0,  1'b0, 3'd0, 4'h0, 32'h0000_0000}, // R10 open bank 1
        {2'd2, 2'd0, 4'd3,  1'b0, 3'd2, 4'h0, 32'hA000_0003}, // R1 BL4 from col 3
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hA000_0000}, // R2 aligned wrap to col 0
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h2, 32'hA000_0001}, // R8 lane 1 masked
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hA000_0002},
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hBAD0_0007}, // R3 ignored
        {2'd2, 2'd1, 4'd6,  1'b0, 3'd1, 4'h0, 32'hB100_0006}, // BL2 into bank 1
        {2'd2, 2'd1, 4'd9,  1'b1, 3'd3, 4'h0, 32'hB100_0009}, // R5 truncation, BL8 with ap
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hB100_000A},
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hB100_000B},
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h8, 32'hB100_000C},
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hB100_000D},
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hB100_000E},
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hB100_000F},
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hB100_0008}, // R7 last word closes bank 1
        {2'd2, 2'd1, 4'd1,  1'b0, 3'd1, 4'h0, 32'hBAD0_0001}, // R7 bank 1 now closed
        {2'd2, 2'd0, 4'd14, 1'b0, 3'd4, 4'h5, 32'hC000_000E}, // R4 full page, mask
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hC000_000F},
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hC000_0000}, // R4 wrap to col 0
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hC000_0001},
        {2'd2, 2'd2, 4'd7,  1'b0, 3'd0, 4'h0, 32'hC000_0002}, // R9 closed bank, burst continues
        {2'd3, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hBAD0_0003}, // R10 precharge ends burst
        {2'd1, 2'd3, 4'd0,  1'b0, 3'd0, 4'h0, 32'h0000_0000},
        {2'd2, 2'd3, 4'd5,  1'b1, 3'd0, 4'h0, 32'hD300_0005}, // R7 BL1 with ap
        {2'd1, 2'd3, 4'd0,  1'b0, 3'd0, 4'h0, 32'h0000_0000},
        {2'd2, 2'd3, 4'd0,  1'b0, 3'd1, 4'h0, 32'hD300_0000},
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hD300_0001},
        {2'd2, 2'd3, 4'd2,  1'b0, 3'd0, 4'h0, 32'hD300_0002}, // R6 no idle cycle
        {2'd1, 2'd2, 4'd0,  1'b0, 3'd0, 4'h0, 32'h0000_0000},
        {2'd2, 2'd2, 4'd0,  1'b1, 3'd2, 4'h0, 32'hD200_0000},
        {2'd2, 2'd2, 4'd8,  1'b0, 3'd0, 4'h0, 32'hD200_0008}, // R7 truncated ap dropped
        {2'd0, 2'd0, 4'd0,  1'b0, 3'd0, 4'h0, 32'hBAD0_000F}  // R3 ignored
    };

    logic              clk;
    logic              rst_n;
    logic [1:0]        cmd;
    logic [1:0]        bank;
    logic [3:0]        col;
    logic              ap;
    logic [2:0]        blen;
    logic [DATA_W-1:0] data;
    logic [LANES-1:0]  mask;
    logic [1:0]        rd_bank;
    logic [3:0]        rd_col;
    logic [DATA_W-1:0] rd_data;
    logic [BANKS-1:0]  bank_open;
    logic              burst;
    logic              err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [DATA_W-1:0] m_mem [BANKS][COLS];
    logic [BANKS-1:0]  m_open;
    logic              m_err;
    logic              m_act;
    int                m_bank, m_base, m_idx, m_len;
    logic              m_full, m_ap;
    int                last_b, last_c;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    sdw_write_seq #(
        .BANKS  (BANKS),
        .COLS   (COLS),
        .DATA_W (DATA_W)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cmd_i       (cmd),
        .bank_i      (bank),
        .col_i       (col),
        .ap_i        (ap),
        .blen_i      (blen),
        .data_i      (data),
        .mask_i      (mask),
        .rd_bank_i   (rd_bank),
        .rd_col_i    (rd_col),
        .rd_data_o   (rd_data),
        .bank_open_o (bank_open),
        .burst_o     (burst),
        .err_o       (err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic m_store(input int b, input int c, input logic [DATA_W-1:0] d,
                           input logic [LANES-1:0] mk);
        for (int l = 0; l < LANES; l++) begin
            if (!mk[l]) m_mem[b][c][l*8 +: 8] = d[l*8 +: 8];
        end
        last_b = b;
        last_c = c;
    endtask

    task automatic m_continue(input logic [DATA_W-1:0] d, input logic [LANES-1:0] mk);
        int c;
        if (m_full) c = (m_base + m_idx) % COLS;
        else c = (m_base / m_len) * m_len + ((m_base + m_idx) % m_len);
        m_store(m_bank, c, d, mk);
        if (!m_full && m_idx == m_len - 1) begin
            m_act = 1'b0;
            if (m_ap) m_open[m_bank] = 1'b0;
        end
        m_idx++;
    endtask

    task automatic m_step(input logic [47:0] v);
        logic [1:0] vc;
        int vb, vcol;
        logic [2:0] vbl;
        vc   = v[47:46];
        vb   = int'(v[45:44]);
        vcol = int'(v[43:40]);
        vbl  = v[38:36];
        m_err = 1'b0;
        case (vc)
            2'd2: begin
                if (!m_open[vb]) begin
                    m_err = 1'b1;
                    if (m_act) m_continue(v[31:0], v[35:32]);
                end else begin
                    m_store(vb, vcol, v[31:0], v[35:32]);
                    m_full = vbl[2];
                    m_len  = 1 << vbl[1:0];
                    if (m_full || m_len > 1) begin
                        m_act  = 1'b1;
                        m_bank = vb;
                        m_base = vcol;
                        m_idx  = 1;
                        m_ap   = v[39];
                    end else begin
                        m_act = 1'b0;
                        if (v[39]) m_open[vb] = 1'b0;
                    end
                end
            end
            2'd1: begin m_act = 1'b0; m_open[vb] = 1'b1; end
            2'd3: begin m_act = 1'b0; m_open[vb] = 1'b0; end
            default: if (m_act) m_continue(v[31:0], v[35:32]);
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd = 2'd0; bank = '0; col = '0; ap = 1'b0; blen = '0;
        data = '0; mask = '0; rd_bank = '0; rd_col = '0;
        for (int b = 0; b < BANKS; b++)
            for (int c = 0; c < COLS; c++) m_mem[b][c] = '0;
        m_open = '0; m_err = 1'b0; m_act = 1'b0; m_full = 1'b0; m_ap = 1'b0;
        m_bank = 0; m_base = 0; m_idx = 0; m_len = 1; last_b = 0; last_c = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 bank_open", 64'(bank_open), 64'(0));
        check("R11 burst", 64'(burst), 64'(0));
        check("R11 err", 64'(err), 64'(0));
        check("R11 word", 64'(rd_data), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            cmd  = VEC[i][47:46];
            bank = VEC[i][45:44];
            col  = VEC[i][43:40];
            ap   = VEC[i][39];
            blen = VEC[i][38:36];
            mask = VEC[i][35:32];
            data = VEC[i][31:0];
            @(posedge clk);
            m_step(VEC[i]);
            @(negedge clk);
            cmd = 2'd0;
            check($sformatf("R9 err vec %0d", i), 64'(err), 64'(m_err));
            check($sformatf("R7 R10 open vec %0d", i), 64'(bank_open), 64'(m_open));
            check($sformatf("R2 R3 burst vec %0d", i), 64'(burst), 64'(m_act));
            rd_bank = 2'(last_b);
            rd_col  = 4'(last_c);
            #1;
            check($sformatf("R1 R5 R8 word vec %0d", i), 64'(rd_data), 64'(m_mem[last_b][last_c]));
        end

        // R2 R4 R6 final sweep of every stored word against the reference array
        for (int b = 0; b < BANKS; b++) begin
            for (int c = 0; c < COLS; c++) begin
                rd_bank = 2'(b);
                rd_col  = 4'(c);
                #1;
                check($sformatf("R2 R4 R6 sweep b%0d c%0d", b, c), 64'(rd_data), 64'(m_mem[b][c]));
            end
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule